// File: doc/BRIEF.md
# Pipelined Burst Static Memory with Lane-Masked Writes

This block is a single-clock synchronous memory. Every control, address and write-data input is sampled on the rising clock edge. An access opens when either of two active-low address strobes is asserted while the chip is selected. The two low address bits then seed a two-bit burst counter. While the advance input is held low, each later cycle moves to the next word of the four-word group, in linear or interleaved order as a mode input selects. Each cycle of an open burst is a write or a read, depending on the write controls sampled in that cycle. Writes may update any subset of byte lanes, and a global write updates every lane. Reads pass through an output register. The result is presented with a drive flag that the asynchronous output enable gates, which stands in for a tristate bus.

A two-state machine tracks the burst. In `ST_IDLE` no access is performed. A strobe with the chip selected moves it to `ST_BURST` (transition *open*). In `ST_BURST` a strobe with the chip selected reloads the address (transition *reload*). A strobe with the chip deselected returns it to `ST_IDLE` (transition *deselect*). A cycle with no strobe keeps the burst going (transition *continue*), and the counter steps only if advance is low. A cycle with no strobe in `ST_IDLE` keeps it idle (transition *stay*).

Top module: `psram_burst_top`

## Requirements
- R1: Inputs presented in cycle n take effect at edge n. Data read in cycle n is presented on `rdata` after edge n+1 and stays until edge n+2.
- R2: A low on `strb_p_n` or on `strb_c_n` with `ce_n` low loads `addr` as the access address, both from idle and in the middle of a burst.
- R3: Without a strobe, the burst offset advances by one step only in cycles where `adv_n` is low. Otherwise the previous word is accessed again.
- R4: With `ilv_mode` low, beat k of a burst accesses low address bits (start + k) mod 4, and the upper address bits stay fixed.
- R5: With `ilv_mode` high, beat k accesses low address bits start XOR k.
- R6: With `bwe_n` low and `gw_n` high, lane i (data bits [9i+8:9i]) is written only when `bw_n[i]` is low. Other lanes keep their contents.
- R7: With `gw_n` low, all lanes are written whatever `bwe_n` and `bw_n` are.
- R8: A cycle with `gw_n` high and either `bwe_n` high or `bw_n` all ones is a read and changes no memory contents. A write cycle never drives `rdata_vld`.
- R9: A strobe with `ce_n` high closes the burst. `rdata_vld` is low from edge n+1 of that cycle n. Later cycles without a strobe neither read nor write.
- R10: While `oe_n` is high, `rdata_vld` is low and `rdata` is zero, without waiting for a clock edge.
- R11: After reset the block is idle, and `rdata_vld` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address; bits [1:0] seed the burst offset |
| strb_p_n | input | 1 | Active-low burst start strobe, first source |
| strb_c_n | input | 1 | Active-low burst start strobe, second source |
| adv_n | input | 1 | Active-low burst advance |
| ce_n | input | 1 | Active-low chip select, sampled with a strobe |
| ilv_mode | input | 1 | 0 = linear order, 1 = interleaved order |
| gw_n | input | 1 | Active-low write of all lanes |
| bwe_n | input | 1 | Active-low qualifier for the per-lane writes |
| bw_n | input | LANES | Active-low per-lane write selects |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_vld | output | 1 | High when the read data is driven |

## Verification
A wrong counter or offset register reads out the wrong word on the very next read beat. Because every address holds a distinct pattern, the mismatch shows on `rdata` one edge after that beat is issued. A burst state that fails to close leaves `rdata_vld` high two edges after a deselecting strobe. A lane-mask error stays hidden until the same word is read back. For that reason every write scenario is followed at once by a read of the words it touched, including the lanes that were supposed to keep their contents.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_st_e;

    typedef enum logic [1:0] {
        AC_NONE  = 2'd0,
        AC_READ  = 2'd1,
        AC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/psram_wr_decode.sv
`timescale 1ns/1ps
module psram_wr_decode #(
    parameter int LANES = 2
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_wr
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // global write overrides the per-lane controls
        assign lane_wr[g] = !gw_n || (!bwe_n && !bw_n[g]);
    end
endmodule

// File: rtl/psram_burst_ctrl.sv
`timescale 1ns/1ps
module psram_burst_ctrl
    import psram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    strb_p_n,
    input  logic                    strb_c_n,
    input  logic                    adv_n,
    input  logic                    ce_n,
    input  logic                    ilv_mode,
    input  logic [LANES-1:0]        lane_wr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output acc_kind_e               acc_kind,
    output logic [AW-1:0]           acc_addr,
    output logic [LANES-1:0]        acc_mask,
    output logic [LANES*LANE_W-1:0] acc_wdata
);
    localparam int DW = LANES * LANE_W;
    localparam int HW = AW - 2;

    burst_st_e   st_q, st_d;
    logic [HW-1:0] base_q, base_d;
    logic [1:0]  off_q, off_d;
    logic [1:0]  cnt_q, cnt_d;
    logic [1:0]  low;
    logic        strobe;
    logic        go;

    always_comb begin
        strobe = !strb_p_n || !strb_c_n;
        st_d   = st_q;
        base_d = base_q;
        off_d  = off_q;
        cnt_d  = cnt_q;
        go     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (strobe && !ce_n) begin          // open
                    st_d   = ST_BURST;
                    base_d = addr[AW-1:2];
                    off_d  = addr[1:0];
                    cnt_d  = 2'd0;
                    go     = 1'b1;
                end                                 // otherwise stay
            end
            ST_BURST: begin
                if (strobe) begin
                    if (!ce_n) begin                // reload
                        base_d = addr[AW-1:2];
                        off_d  = addr[1:0];
                        cnt_d  = 2'd0;
                        go     = 1'b1;
                    end else begin                  // deselect
                        st_d = ST_IDLE;
                    end
                end else begin                      // continue
                    go = 1'b1;
                    if (!adv_n) begin
                        cnt_d = cnt_q + 2'd1;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
        low = ilv_mode ? (off_d ^ cnt_d) : (off_d + cnt_d);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            base_q <= '0;
            off_q  <= '0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            base_q <= base_d;
            off_q  <= off_d;
            cnt_q  <= cnt_d;
        end
    end

    // registered access outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_kind  <= AC_NONE;
            acc_addr  <= '0;
            acc_mask  <= '0;
            acc_wdata <= '0;
        end else begin
            if (!go)           acc_kind <= AC_NONE;
            else if (|lane_wr) acc_kind <= AC_WRITE;
            else               acc_kind <= AC_READ;
            acc_addr  <= {base_d, low};
            acc_mask  <= lane_wr;
            acc_wdata <= wdata[DW-1:0];
        end
    end

    // R3: offset holds without advance
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BURST && strb_p_n && strb_c_n && adv_n) |=> $stable(cnt_q))
        else $error("a_r3_hold");

    // R3: offset steps by one with advance
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BURST && strb_p_n && strb_c_n && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1))
        else $error("a_r3_step");

    // R2: a selected strobe always produces an access next cycle
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        ((!strb_p_n || !strb_c_n) && !ce_n) |=> (acc_kind != AC_NONE && st_q == ST_BURST))
        else $error("a_r2_start");
endmodule

// File: rtl/psram_lane_array.sv
`timescale 1ns/1ps
module psram_lane_array
    import psram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  acc_kind_e               acc_kind,
    input  logic [AW-1:0]           acc_addr,
    input  logic [LANES-1:0]        acc_mask,
    input  logic [LANES*LANE_W-1:0] acc_wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_vld
);
    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] out_word;
    logic          drive_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (acc_kind == AC_WRITE && acc_mask[g]) begin
                bank[acc_addr] <= acc_wdata[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  q <= '0;
            else if (acc_kind == AC_READ) q <= bank[acc_addr];
        end

        assign out_word[g*LANE_W +: LANE_W] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
        end else begin
            unique case (acc_kind)
                AC_READ:  drive_q <= 1'b1;
                AC_WRITE: drive_q <= 1'b0;
                default:  drive_q <= 1'b0;  // single-cycle deselect
            endcase
        end
    end

    assign rdata_vld = drive_q && !oe_n;
    assign rdata     = rdata_vld ? out_word : '0;

    // R8: a write beat never drives the bus on the following cycle
    a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == AC_WRITE) |=> !rdata_vld)
        else $error("a_r8_write_quiet");
endmodule

// File: rtl/psram_burst_top.sv
`timescale 1ns/1ps
module psram_burst_top
    import psram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    strb_p_n,
    input  logic                    strb_c_n,
    input  logic                    adv_n,
    input  logic                    ce_n,
    input  logic                    ilv_mode,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_vld
);
    localparam int DW = LANES * LANE_W;

    logic [LANES-1:0] lane_wr;
    acc_kind_e        acc_kind;
    logic [AW-1:0]    acc_addr;
    logic [LANES-1:0] acc_mask;
    logic [DW-1:0]    acc_wdata;

    psram_wr_decode #(.LANES(LANES)) u_dec (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_wr (lane_wr)
    );

    psram_burst_ctrl #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .strb_p_n  (strb_p_n),
        .strb_c_n  (strb_c_n),
        .adv_n     (adv_n),
        .ce_n      (ce_n),
        .ilv_mode  (ilv_mode),
        .lane_wr   (lane_wr),
        .wdata     (wdata),
        .acc_kind  (acc_kind),
        .acc_addr  (acc_addr),
        .acc_mask  (acc_mask),
        .acc_wdata (acc_wdata)
    );

    psram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_kind  (acc_kind),
        .acc_addr  (acc_addr),
        .acc_mask  (acc_mask),
        .acc_wdata (acc_wdata),
        .oe_n      (oe_n),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    // R9: deselect silences the bus from the second edge on
    a_r9_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        ((!strb_p_n || !strb_c_n) && ce_n) |=> ##1 !rdata_vld)
        else $error("a_r9_deselect");

    // R7: global write forces every lane and never yields a read
    a_r7_global: assert property (@(posedge clk) disable iff (!rst_n)
        !gw_n |=> (acc_kind != AC_READ && (&acc_mask)))
        else $error("a_r7_global");

    // R10: output enable high keeps the bus quiet
    a_r10_oe: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rdata_vld && rdata == '0))
        else $error("a_r10_oe");
endmodule

// File: tb/test_psram_burst_top.sv
`timescale 1ns/1ps
module test_psram_burst_top;
    localparam int AW     = 6;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;
    localparam int DEPTH  = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic [AW-1:0]    addr;
    logic             strb_p_n, strb_c_n, adv_n, ce_n, ilv_mode;
    logic             gw_n, bwe_n, oe_n;
    logic [LANES-1:0] bw_n;
    logic [DW-1:0]    wdata;
    logic [DW-1:0]    rdata;
    logic             rdata_vld;

    psram_burst_top #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_psram_burst_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strb_p_n(strb_p_n), .strb_c_n(strb_c_n),
        .adv_n(adv_n), .ce_n(ce_n), .ilv_mode(ilv_mode), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_vld(rdata_vld)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    string req_tag = "R11";

    // reference model
    logic [DW-1:0]   ref_mem [DEPTH];
    logic            m_act = 1'b0;
    logic [AW-3:0]   m_base = '0;
    logic [1:0]      m_off = '0, m_cnt = '0;
    int              pend_kind = 0;   // 0 none, 1 read, 2 write
    logic [DW-1:0]   pend_data = '0;

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 311) ^ 18'h2A5A5;
    endfunction

    task automatic check(string tag, logic [DW:0] act, logic [DW:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got vld=%0b data=%h, expected vld=%0b data=%h",
                     tag, act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
        end
    endtask

    task automatic idle_in();
        addr = '0; strb_p_n = 1; strb_c_n = 1; adv_n = 1; ce_n = 0; ilv_mode = 0;
        gw_n = 1; bwe_n = 1; bw_n = '1; wdata = '0; oe_n = 0;
    endtask

    // one clock: model the beat, run the edge, check the previous beat
    task automatic beat();
        logic go;
        logic [1:0] lo;
        logic [AW-1:0] a;
        logic [LANES-1:0] msk;
        int kind;
        go = 1'b0;
        if (!strb_p_n || !strb_c_n) begin
            if (!ce_n) begin
                m_base = addr[AW-1:2]; m_off = addr[1:0]; m_cnt = 2'd0; m_act = 1'b1; go = 1'b1;
            end else begin
                m_act = 1'b0;
            end
        end else if (m_act) begin
            go = 1'b1;
            if (!adv_n) m_cnt = m_cnt + 2'd1;
        end
        lo = ilv_mode ? (m_off ^ m_cnt) : (m_off + m_cnt);
        a  = {m_base, lo};
        if (!gw_n)       msk = '1;
        else if (!bwe_n) msk = ~bw_n;
        else             msk = '0;
        kind = 0;
        if (go && msk != 0) begin
            kind = 2;
            for (int g = 0; g < LANES; g++)
                if (msk[g]) ref_mem[a][g*LANE_W +: LANE_W] = wdata[g*LANE_W +: LANE_W];
        end else if (go) begin
            kind = 1;
        end
        @(posedge clk);
        @(negedge clk);
        if (pend_kind == 1 && !oe_n) check(req_tag, {rdata_vld, rdata}, {1'b1, pend_data});
        else                         check(req_tag, {rdata_vld, rdata}, {1'b0, {DW{1'b0}}});
        pend_kind = kind;
        pend_data = (kind == 1) ? ref_mem[a] : '0;
    endtask

    task automatic t_reset();
        req_tag = "R11";
        check("R11", {rdata_vld, rdata}, {1'b0, {DW{1'b0}}});
        idle_in(); beat();   // no strobe while idle: nothing happens
    endtask

    task automatic t_fill();
        req_tag = "R7";      // R2: both strobes used alternately
        for (int i = 0; i < DEPTH; i++) begin
            idle_in(); addr = AW'(i); gw_n = 0; wdata = pat(i);
            if (i % 2 == 0) strb_p_n = 0; else strb_c_n = 0;
            beat();
        end
        idle_in(); beat();
    endtask

    // R1 timing is checked on every beat; R4 linear, R5 interleaved
    task automatic t_burst(bit ilv);
        req_tag = ilv ? "R5" : "R4";
        for (int s = 0; s < 4; s++) begin
            idle_in(); ilv_mode = ilv; addr = AW'(((s * 3 + 1) % 16) * 4 + s);
            if (s % 2 == 0) strb_p_n = 0; else strb_c_n = 0;
            beat();
            for (int k = 1; k < 5; k++) begin
                idle_in(); ilv_mode = ilv; adv_n = 0; beat();
            end
        end
        idle_in(); ce_n = 1; strb_p_n = 0; beat();
        idle_in(); beat();
    endtask

    task automatic t_hold();
        req_tag = "R3";
        idle_in(); addr = 6'd22; strb_c_n = 0; beat();
        idle_in(); beat();
        idle_in(); beat();
        idle_in(); adv_n = 0; beat();
        idle_in(); beat();
        req_tag = "R2";      // reload mid-burst with the other strobe
        idle_in(); addr = 6'd50; strb_p_n = 0; beat();
        idle_in(); adv_n = 0; beat();
        idle_in(); ce_n = 1; strb_c_n = 0; beat();
        idle_in(); beat();
    endtask

    task automatic t_bytes();
        req_tag = "R6";
        idle_in(); addr = 6'd40; strb_p_n = 0; bwe_n = 0; bw_n = 2'b10; wdata = '1; beat();
        idle_in(); addr = 6'd40; strb_c_n = 0; beat();
        idle_in(); addr = 6'd41; strb_p_n = 0; bwe_n = 0; bw_n = 2'b01; wdata = 18'h1_2345; beat();
        idle_in(); adv_n = 0; bwe_n = 0; bw_n = 2'b10; wdata = 18'h0_0F0F; beat();
        idle_in(); adv_n = 0; bwe_n = 0; bw_n = 2'b00; wdata = 18'h2_AAAA; beat();
        idle_in(); addr = 6'd40; strb_p_n = 0; beat();
        for (int k = 0; k < 3; k++) begin
            idle_in(); adv_n = 0; beat();
        end
        req_tag = "R8";
        idle_in(); addr = 6'd41; strb_p_n = 0; bwe_n = 1; bw_n = 2'b00; wdata = 18'h3_FFFF; beat();
        idle_in(); addr = 6'd42; strb_c_n = 0; bwe_n = 0; bw_n = 2'b11; wdata = 18'h3_FFFF; beat();
        idle_in(); addr = 6'd41; strb_p_n = 0; beat();
        idle_in(); adv_n = 0; beat();
        idle_in(); ce_n = 1; strb_p_n = 0; beat();
        idle_in(); beat();
    endtask

    task automatic t_global();
        req_tag = "R7";
        idle_in(); addr = 6'd12; strb_p_n = 0; gw_n = 0; bwe_n = 0; bw_n = 2'b10; wdata = 18'h1_5A5A; beat();
        idle_in(); addr = 6'd13; strb_c_n = 0; gw_n = 0; bwe_n = 1; bw_n = 2'b11; wdata = 18'h2_0C3C; beat();
        idle_in(); addr = 6'd12; strb_p_n = 0; beat();
        idle_in(); adv_n = 0; beat();
        idle_in(); ce_n = 1; strb_c_n = 0; beat();
        idle_in(); beat();
    endtask

    task automatic t_deselect();
        req_tag = "R9";
        idle_in(); addr = 6'd7; strb_p_n = 0; beat();
        idle_in(); ce_n = 1; strb_c_n = 0; beat();
        idle_in(); adv_n = 0; beat();
        idle_in(); gw_n = 0; wdata = '0; beat();    // idle: must not write
        idle_in(); addr = 6'd7; strb_p_n = 0; beat();
        idle_in(); beat();
    endtask

    task automatic t_oe();
        req_tag = "R10";
        idle_in(); addr = 6'd9; strb_c_n = 0; beat();
        idle_in(); adv_n = 0; oe_n = 1; beat();
        idle_in(); adv_n = 0; beat();
        idle_in(); oe_n = 1; beat();
        idle_in(); ce_n = 1; strb_p_n = 0; beat();
        idle_in(); beat();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle_in();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_fill();
        t_burst(1'b0);
        t_burst(1'b1);
        t_hold();
        t_bytes();
        t_global();
        t_deselect();
        t_oe();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule